// File: doc/BRIEF.md
# Bad Line Detector and Bus Arbiter

This block runs once per video cycle. In every cycle it decides whether the current raster line is a bad line, a line on which the video controller must take the memory bus to fetch character pointers and colour data. It then drives the two bus-arbitration outputs that stall the processor: `ba_o` warns that the bus is about to be taken, and `aec_o` releases the address bus to the processor during the second clock phase. It also drives a per-cycle enable for the character/colour fetch logic and a one-cycle pulse that moves the graphics sequencer from idle into display state.

The condition can become true partway through a line, either because the vertical scroll field is rewritten to match the raster counter or because display-enable is switched on during the first line of the window. Arbitration therefore starts from whatever cycle the condition appears in. `aec_o` keeps following the phase-2 level for a fixed number of cycles after `ba_o` drops, before the bus is really taken. A late trigger therefore gives a fetch window that starts late and is shorter than normal, and it still ends at the usual last fetch cycle.

The cycle counter (1..63), raster counter, scroll field and enable bit come from neighbouring logic. Each `clk` edge ends one video cycle. `phi2_i` is the phase-2 level within the current cycle.

Top module: `badline_arbiter`

## Requirements
- R1: `bad_line_o` is high in a cycle exactly when the enable latch is set, the raster line lies in 0x30..0xF7 inclusive, and `raster_i[2:0]` equals `yscroll_i`. It reflects that cycle's inputs in the same cycle.
- R2: The enable latch is set by `den_i` being high in any cycle of raster line 0x30, and takes effect from the following cycle. `den_i` on any other line has no effect on the latch.
- R3: The enable latch clears on raster line 0, so a new frame has no bad lines until display-enable is seen again on line 0x30.
- R4: If the condition holds in a cycle c with 11 ≤ c ≤ 53, `ba_o` is low in cycle c+1. A normal bad line therefore drops `ba_o` in cycle 12. `ba_o` is high in cycle 55 and later, and in any cycle whose previous cycle did not request the bus.
- R5: While `ba_o` is high, and in the first three cycles in which it is low, `aec_o` equals `phi2_i`. From the fourth consecutive low cycle onward, `aec_o` is held low whatever `phi2_i` is.
- R6: `fetch_en_o` is high exactly in the cycles from 15 to 54 inclusive in which `ba_o` is low. A trigger in cycle c ≥ 14 therefore fetches from c+1 through 54.
- R7: `force_disp_o` pulses for one cycle, in the cycle after the first cycle of the line in 15..53 in which the condition holds. A normal bad line pulses in cycle 16. A condition first true in cycle 54 or later gives no pulse.
- R8: While `rst_n` is low and in the first cycle after reset, `ba_o` is high, `fetch_en_o` and `force_disp_o` are low, `aec_o` follows `phi2_i`, and the enable latch is clear.
- R9: A matching scroll value on a line outside 0x30..0xF7 (for example 0x2F or 0xF8) raises neither `bad_line_o` nor `ba_o`, even with the latch set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | One rising edge per video cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| raster_i | input | 9 | Current raster line |
| cycle_i | input | 7 | Cycle number within the line, 1..63 |
| yscroll_i | input | 3 | Vertical scroll field |
| den_i | input | 1 | Display-enable bit |
| phi2_i | input | 1 | Phase-2 clock level |
| bad_line_o | output | 1 | Bad line condition for this cycle |
| ba_o | output | 1 | Bus available; low warns the processor |
| aec_o | output | 1 | Address enable; low keeps the processor off the bus |
| fetch_en_o | output | 1 | Character/colour fetch enable for this cycle |
| force_disp_o | output | 1 | One-cycle pulse forcing display state |

## Verification
`bad_line_o` is combinational and is due in the cycle whose inputs produce it. `ba_o`, `fetch_en_o` and `force_disp_o` each pass through one register and are due in the next cycle. The hold on `aec_o` arrives three cycles after that, and a change of `den_i` reaches the condition one cycle later through the latch. The bench changes inputs on the falling edge, so one cycle's inputs are stable before the rising edge that closes it. It then samples 1 ns later, against expectations worked out in closed form from the cycle in which the condition first holds. Within each cycle it samples `aec_o` twice, once with `phi2_i` high and once low. The sweep moves the trigger cycle across every boundary of the 11/14/15/53/54 range and covers lines at both edges of the window.

// File: rtl/badline_pkg.sv
// Shared types for the bad line detector and bus arbiter.
// Assumes one clock edge per video cycle.
package badline_pkg;

    // Arbitration phase: bus free, bus requested but AEC still lagging,
    // or bus fully taken.
    typedef enum logic [1:0] {
        ARB_IDLE   = 2'd0,
        ARB_LAG    = 2'd1,
        ARB_STOLEN = 2'd2
    } arb_state_t;

endpackage

// File: rtl/badline_detect.sv
// Bad line condition detector.
// Keeps the frame's display-enable latch and evaluates the bad line
// condition combinationally from the current cycle's inputs.
// Assumes raster_i and yscroll_i are stable for the whole cycle.
module badline_detect #(
    parameter int RASTER_W  = 9,
    parameter int YS_W      = 3,
    parameter int WIN_FIRST = 48,
    parameter int WIN_LAST  = 247,
    parameter int DEN_LINE  = 48,
    parameter int CLR_LINE  = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RASTER_W-1:0] raster_i,
    input  logic [YS_W-1:0]     yscroll_i,
    input  logic                den_i,
    output logic                bad_line_o
);

    localparam logic [RASTER_W-1:0] WIN_LO  = RASTER_W'(WIN_FIRST);
    localparam logic [RASTER_W-1:0] WIN_HI  = RASTER_W'(WIN_LAST);
    localparam logic [RASTER_W-1:0] DEN_LN  = RASTER_W'(DEN_LINE);
    localparam logic [RASTER_W-1:0] CLR_LN  = RASTER_W'(CLR_LINE);

    logic den_seen_q;
    logic in_window;
    logic scroll_match;

    // Latch display-enable seen on the enable line; clear at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            den_seen_q <= 1'b0;
        end else if (raster_i == CLR_LN) begin
            den_seen_q <= 1'b0;
        end else if (raster_i == DEN_LN && den_i) begin
            den_seen_q <= 1'b1;
        end
    end

    // Evaluate the window, the scroll match and the combined condition.
    always_comb begin
        in_window    = (raster_i >= WIN_LO) && (raster_i <= WIN_HI);
        scroll_match = (raster_i[YS_W-1:0] == yscroll_i);
        bad_line_o   = den_seen_q && in_window && scroll_match;
    end

endmodule

// File: rtl/badline_bus_arb.sv
// Bus arbiter: turns the bad line condition into BA and the AEC hold.
// BA drops the cycle after a request. AEC keeps following phi2 for
// AEC_LAG cycles and is then held low until the request ends.
// Assumes AEC_LAG >= 1 and that the cycle numbering starts at 1.
module badline_bus_arb
    import badline_pkg::*;
#(
    parameter int CYCLE_W    = 7,
    parameter int BA_START   = 12,
    parameter int FETCH_LAST = 54,
    parameter int AEC_LAG    = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bad_line_i,
    input  logic [CYCLE_W-1:0] cycle_i,
    output logic               ba_low_o,
    output logic               aec_hold_o
);

    localparam int LAG_W = (AEC_LAG > 1) ? $clog2(AEC_LAG) : 1;
    localparam logic [CYCLE_W-1:0] REQ_LO  = CYCLE_W'(BA_START - 1);
    localparam logic [CYCLE_W-1:0] REQ_HI  = CYCLE_W'(FETCH_LAST - 1);
    localparam logic [LAG_W-1:0]   LAG_END = LAG_W'(AEC_LAG - 1);

    arb_state_t       state_q;
    logic [LAG_W-1:0] lag_q;
    logic             req;

    // Request the bus while the condition holds inside the request range.
    always_comb begin
        req = bad_line_i && (cycle_i >= REQ_LO) && (cycle_i <= REQ_HI);
    end

    // Step the arbitration phase and count the lagging AEC cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            lag_q   <= '0;
        end else if (!req) begin
            state_q <= ARB_IDLE;
            lag_q   <= '0;
        end else begin
            case (state_q)
                ARB_IDLE: begin
                    state_q <= ARB_LAG;
                    lag_q   <= '0;
                end
                ARB_LAG: begin
                    if (lag_q == LAG_END) begin
                        state_q <= ARB_STOLEN;
                    end else begin
                        lag_q <= lag_q + LAG_W'(1);
                    end
                end
                default: state_q <= ARB_STOLEN;
            endcase
        end
    end

    // Decode the outputs from the phase.
    always_comb begin
        ba_low_o   = (state_q != ARB_IDLE);
        aec_hold_o = (state_q == ARB_STOLEN);
    end

endmodule

// File: rtl/badline_fetch_gate.sv
// Fetch window gate and display-state forcing pulse.
// Fetches run in the cycles of the fetch range while the bus is
// requested. The force pulse fires once per line, in the cycle after the
// first cycle in FETCH_FIRST..FETCH_LAST-1 in which the condition holds.
// Assumes the cycle counter passes through values below FETCH_FIRST on
// every line.
module badline_fetch_gate #(
    parameter int CYCLE_W     = 7,
    parameter int FETCH_FIRST = 15,
    parameter int FETCH_LAST  = 54
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bad_line_i,
    input  logic               ba_low_i,
    input  logic [CYCLE_W-1:0] cycle_i,
    output logic               fetch_en_o,
    output logic               force_disp_o
);

    localparam logic [CYCLE_W-1:0] F_LO   = CYCLE_W'(FETCH_FIRST);
    localparam logic [CYCLE_W-1:0] F_HI   = CYCLE_W'(FETCH_LAST);
    localparam logic [CYCLE_W-1:0] TRG_HI = CYCLE_W'(FETCH_LAST - 1);

    logic fired_q;
    logic pulse_q;
    logic trig;

    // Fetch while the bus is requested inside the fetch range; find the
    // first trigger of this line.
    always_comb begin
        fetch_en_o = ba_low_i && (cycle_i >= F_LO) && (cycle_i <= F_HI);
        trig       = bad_line_i && !fired_q &&
                     (cycle_i >= F_LO) && (cycle_i <= TRG_HI);
    end

    // Register the one-shot pulse and re-arm it early in every line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= trig;
            if (cycle_i < F_LO) begin
                fired_q <= 1'b0;
            end else if (trig) begin
                fired_q <= 1'b1;
            end
        end
    end

    // Drive the pulse output.
    always_comb begin
        force_disp_o = pulse_q;
    end

endmodule

// File: rtl/badline_arbiter.sv
// Top of the bad line detector and bus arbiter.
// Combines the condition detector, the BA/AEC arbiter and the fetch gate.
// Assumes one clk edge per video cycle and phi2_i giving the phase level.
module badline_arbiter #(
    parameter int RASTER_W    = 9,
    parameter int CYCLE_W     = 7,
    parameter int YS_W        = 3,
    parameter int WIN_FIRST   = 48,
    parameter int WIN_LAST    = 247,
    parameter int DEN_LINE    = 48,
    parameter int CLR_LINE    = 0,
    parameter int BA_START    = 12,
    parameter int FETCH_FIRST = 15,
    parameter int FETCH_LAST  = 54,
    parameter int AEC_LAG     = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [RASTER_W-1:0] raster_i,
    input  logic [CYCLE_W-1:0]  cycle_i,
    input  logic [YS_W-1:0]     yscroll_i,
    input  logic                den_i,
    input  logic                phi2_i,
    output logic                bad_line_o,
    output logic                ba_o,
    output logic                aec_o,
    output logic                fetch_en_o,
    output logic                force_disp_o
);

    logic bad_line;
    logic ba_low;
    logic aec_hold;

    badline_detect #(
        .RASTER_W (RASTER_W),
        .YS_W     (YS_W),
        .WIN_FIRST(WIN_FIRST),
        .WIN_LAST (WIN_LAST),
        .DEN_LINE (DEN_LINE),
        .CLR_LINE (CLR_LINE)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .raster_i  (raster_i),
        .yscroll_i (yscroll_i),
        .den_i     (den_i),
        .bad_line_o(bad_line)
    );

    badline_bus_arb #(
        .CYCLE_W   (CYCLE_W),
        .BA_START  (BA_START),
        .FETCH_LAST(FETCH_LAST),
        .AEC_LAG   (AEC_LAG)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .bad_line_i(bad_line),
        .cycle_i   (cycle_i),
        .ba_low_o  (ba_low),
        .aec_hold_o(aec_hold)
    );

    badline_fetch_gate #(
        .CYCLE_W    (CYCLE_W),
        .FETCH_FIRST(FETCH_FIRST),
        .FETCH_LAST (FETCH_LAST)
    ) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .bad_line_i  (bad_line),
        .ba_low_i    (ba_low),
        .cycle_i     (cycle_i),
        .fetch_en_o  (fetch_en_o),
        .force_disp_o(force_disp_o)
    );

    // Drive the bus-arbitration outputs.
    always_comb begin
        bad_line_o = bad_line;
        ba_o       = !ba_low;
        aec_o      = phi2_i && !aec_hold;
    end

endmodule

// File: rtl/badline_arbiter_chk.sv
// Property checker for badline_arbiter, attached with bind below.
// Counts consecutive BA-low cycles so that the AEC lag is checked without
// a parameter-sized $past depth.
module badline_arbiter_chk #(
    parameter int RASTER_W    = 9,
    parameter int CYCLE_W     = 7,
    parameter int WIN_FIRST   = 48,
    parameter int WIN_LAST    = 247,
    parameter int BA_START    = 12,
    parameter int FETCH_FIRST = 15,
    parameter int FETCH_LAST  = 54,
    parameter int AEC_LAG     = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [RASTER_W-1:0] raster_i,
    input logic [CYCLE_W-1:0]  cycle_i,
    input logic                phi2_i,
    input logic                bad_line_o,
    input logic                ba_o,
    input logic                aec_o,
    input logic                fetch_en_o,
    input logic                force_disp_o
);

    int low_run;

    // Count consecutive cycles with BA low.
    always_ff @(posedge clk) begin
        if (!rst_n || ba_o) begin
            low_run <= 0;
        end else if (low_run < AEC_LAG + 1) begin
            low_run <= low_run + 1;
        end
    end

    // R4
    ba_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bad_line_o && int'(cycle_i) >= BA_START - 1 &&
         int'(cycle_i) <= FETCH_LAST - 1) |=> !ba_o);

    // R4
    ba_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cycle_i) > FETCH_LAST) |-> ba_o);

    // R5
    aec_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ba_o || low_run < AEC_LAG) |-> (aec_o == phi2_i));

    // R5
    aec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_o && low_run >= AEC_LAG) |-> !aec_o);

    // R6
    fetch_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en_o |-> (!ba_o && int'(cycle_i) >= FETCH_FIRST &&
                        int'(cycle_i) <= FETCH_LAST));

    // R7
    force_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_disp_o |=> !force_disp_o);

    // R9
    window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(raster_i) < WIN_FIRST || int'(raster_i) > WIN_LAST) |->
        !bad_line_o);

endmodule

bind badline_arbiter badline_arbiter_chk #(
    .RASTER_W   (RASTER_W),
    .CYCLE_W    (CYCLE_W),
    .WIN_FIRST  (WIN_FIRST),
    .WIN_LAST   (WIN_LAST),
    .BA_START   (BA_START),
    .FETCH_FIRST(FETCH_FIRST),
    .FETCH_LAST (FETCH_LAST),
    .AEC_LAG    (AEC_LAG)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .raster_i    (raster_i),
    .cycle_i     (cycle_i),
    .phi2_i      (phi2_i),
    .bad_line_o  (bad_line_o),
    .ba_o        (ba_o),
    .aec_o       (aec_o),
    .fetch_en_o  (fetch_en_o),
    .force_disp_o(force_disp_o)
);

// File: tb/badline_arbiter_test.sv
// Self-checking sweep over trigger cycles and raster lines.
module badline_arbiter_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [8:0] raster_i = '0;
    logic [6:0] cycle_i = 7'd1;
    logic [2:0] yscroll_i = '0;
    logic       den_i = 1'b0;
    logic       phi2_i = 1'b1;
    logic       bad_line_o, ba_o, aec_o, fetch_en_o, force_disp_o;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    badline_arbiter uut (
        .clk(clk), .rst_n(rst_n), .raster_i(raster_i), .cycle_i(cycle_i),
        .yscroll_i(yscroll_i), .den_i(den_i), .phi2_i(phi2_i),
        .bad_line_o(bad_line_o), .ba_o(ba_o), .aec_o(aec_o),
        .fetch_en_o(fetch_en_o), .force_disp_o(force_disp_o)
    );

    always #5 clk = ~clk;

    task automatic check(input bit ok, input string req, input int line,
                         input int cyc, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s line=%0h cycle=%0d actual=%0d expected=%0d",
                     req, line, cyc, act, exp);
        end
    endtask

    // Run one line. The scroll field switches from ys_a to ys_b at cycle
    // sw, and den_i switches from den_a to den_b at cycle dsw. exp_t is
    // the first cycle in which the condition is expected (64 = none).
    task automatic run_line(input int r, input int ys_a, input int ys_b,
                            input int sw, input bit den_a, input bit den_b,
                            input int dsw, input int exp_t);
        int s;
        s = (exp_t <= 53) ? ((exp_t > 11 ? exp_t : 11) + 1) : 99;
        for (int k = 1; k <= 63; k++) begin
            bit e_bl, e_ba, e_hold, e_fe, e_fd;
            @(negedge clk);
            raster_i  = 9'(r);
            cycle_i   = 7'(k);
            yscroll_i = 3'((k >= sw) ? ys_b : ys_a);
            den_i     = (k >= dsw) ? den_b : den_a;
            phi2_i    = 1'b1;
            #1;
            e_bl   = (k >= exp_t);
            e_ba   = !(k >= s && k <= 54);
            e_hold = (k >= s + 3 && k <= 54);
            e_fe   = (k >= (s > 15 ? s : 15) && k <= 54);
            e_fd   = (exp_t <= 53) && (k == (exp_t > 15 ? exp_t : 15) + 1);
            // R1 R2 R3 R9: condition in the same cycle
            check(bad_line_o == e_bl, "R1", r, k, bad_line_o, e_bl);
            // R4: BA one cycle after the condition
            check(ba_o == e_ba, "R4", r, k, ba_o, e_ba);
            // R5: AEC with phi2 high
            check(aec_o == !e_hold, "R5", r, k, aec_o, !e_hold);
            // R6: fetch window
            check(fetch_en_o == e_fe, "R6", r, k, fetch_en_o, e_fe);
            // R7: forcing pulse
            check(force_disp_o == e_fd, "R7", r, k, force_disp_o, e_fd);
            phi2_i = 1'b0;
            #1;
            // R5: AEC low in the first phase
            check(aec_o == 1'b0, "R5", r, k, aec_o, 0);
        end
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int t_list[13] = '{1, 5, 11, 12, 13, 14, 15, 16, 30, 52, 53, 54, 60};
        // R8: reset state
        raster_i = 9'h38; yscroll_i = 3'd0; den_i = 1'b1;
        repeat (3) @(negedge clk);
        phi2_i = 1'b1; #1;
        check(ba_o == 1'b1, "R8", 'h38, 0, ba_o, 1);
        check(fetch_en_o == 1'b0, "R8", 'h38, 0, fetch_en_o, 0);
        check(force_disp_o == 1'b0, "R8", 'h38, 0, force_disp_o, 0);
        check(aec_o == 1'b1, "R8", 'h38, 0, aec_o, 1);
        phi2_i = 1'b0; #1;
        check(aec_o == 1'b0, "R8", 'h38, 0, aec_o, 0);
        // R8: latch clear after reset, so a matching line is not bad
        check(bad_line_o == 1'b0, "R8", 'h38, 0, bad_line_o, 0);
        @(negedge clk); rst_n = 1'b1;
        run_line('h38, 0, 0, 1, 1'b1, 1'b1, 1, 64);

        // R3: frame start, then R2: DEN set mid-line on line 0x30
        run_line('h00, 0, 0, 1, 1'b0, 1'b0, 1, 64);
        run_line('h30, 0, 0, 1, 1'b0, 1'b1, 20, 21);

        // R4 R5 R6 R7: trigger cycle sweep via scroll rewrite
        for (int i = 0; i < 13; i++) begin
            int r;
            r = 'h31 + i;
            run_line(r, (r + 1) & 7, r & 7, t_list[i], 1'b0, 1'b0, 1,
                     t_list[i] <= 63 ? t_list[i] : 64);
        end

        // R1: last window line; R9: lines just outside the window
        run_line('hF7, 7, 7, 1, 1'b0, 1'b0, 1, 1);
        run_line('hF8, 0, 0, 1, 1'b0, 1'b0, 1, 64);
        run_line('h2F, 7, 7, 1, 1'b0, 1'b0, 1, 64);

        // R3: new frame clears the latch; R2: DEN off line 0x30 ignored
        run_line('h00, 0, 0, 1, 1'b1, 1'b1, 1, 64);
        run_line('h38, 0, 0, 1, 1'b1, 1'b1, 1, 64);
        // R2: DEN from cycle 1 on line 0x30 gives a normal bad line
        run_line('h30, 0, 0, 1, 1'b1, 1'b1, 1, 2);
        run_line('h31, 1, 1, 1, 1'b0, 1'b0, 1, 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule